// File: doc/BRIEF.md
# 8-bit ALU with Registered Status Flags

This block is the arithmetic and logic unit for an 8-bit datapath. It takes an accumulator operand, a second operand and a 4-bit operation code. When the load strobe is high, the 8-bit result and a status flag byte are captured on the rising clock edge. The flag byte holds sign, zero, half-carry, parity/overflow, add/subtract and carry.

The parity/overflow bit has two meanings. After a logic, shift or rotate operation it holds the parity of the result. After an arithmetic operation it holds signed overflow. The half-carry and add/subtract bits are kept so that a later decimal-correction step can use them. The registered carry bit is the carry input for add-with-carry, subtract-with-borrow and the rotates through carry.

A separate write port loads the whole flag byte directly, and the flag output is always readable. The flag byte has a fixed layout with two unused positions.

Top module: `alu8_core`

## Requirements
- R1: When `ld_i` is high and the opcode is add (0) or add-with-carry (1), the result becomes (a + b + cin) mod 256, and flag bit 0 (C) is set exactly when the true sum exceeds 255. Here cin is the registered C flag for opcode 1 and 0 for opcode 0.
- R2: For subtract (2) and subtract-with-borrow (3), the result becomes (a - b - cin) mod 256, and C is set exactly when a borrow occurs (a < b + cin). Here cin is the registered C flag for opcode 3 and 0 for opcode 2.
- R3: After opcodes 0 to 3, flag bit 2 (P/V) is set exactly when the true signed result lies outside -128..+127. For example, 0x78 + 0x69 gives 0xE1 with P/V=1 and C=0, and 0xFB + 0xF0 gives 0xEB with C=1 and P/V=0.
- R4: After opcodes 0 to 3, flag bit 4 (H) holds the carry out of bit 3 (for addition) or the borrow out of bit 3 (for subtraction).
- R5: Flag bit 1 (N) is set by opcodes 2 and 3 and cleared by every other valid opcode.
- R6: AND (4), OR (5) and XOR (6) produce the bitwise result and clear C and N. They set P/V when the result has an even number of ones. H is set by AND and cleared by OR and XOR.
- R7: The four shift and rotate opcodes ignore b, clear H and N, and set P/V to the even parity of the result. Rotate left through carry (7) gives {a[6:0], C} and rotate right through carry (8) gives {C, a[7:1]}. Shift left (9) gives {a[6:0], 0} and logical shift right (10) gives {0, a[7:1]}. In each case C receives the bit shifted out.
- R8: After any valid operation, flag bit 7 (S) equals bit 7 of the result, and flag bit 6 (Z) is set exactly when the result is 0x00.
- R9: Flag byte layout from bit 7 down to bit 0 is S, Z, unused, H, unused, P/V, N, C. The unused bits 5 and 3 always read 0, even after a flag write that sets them.
- R10: With `ld_i` low, or with an opcode from 11 to 15, the result and the flags keep their values.
- R11: With `flag_we_i` high, the flag byte takes `flag_wdata_i` (with bits 5 and 3 cleared) on the next edge. This write takes priority over the flags of a simultaneous load, while the result of that load is still captured.
- R12: While `rst_ni` is low, the result and the flag byte are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Commit the result and flags of the current operation |
| op_i | input | 4 | Operation code (0-10 valid) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| flag_we_i | input | 1 | Direct flag byte write strobe |
| flag_wdata_i | input | 8 | Flag byte write data |
| res_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered flag byte |

## Verification
The assertions check the following on every cycle:
- the unused flag bits stay zero;
- sign and zero agree with the captured result;
- N and the logic-operation C/N clearing behave as required;
- the registers hold when nothing commits;
- a direct flag write lands masked.

The arithmetic content of the flags can only be shown by the bench's sweeps. This covers carry and borrow, half-carry, signed overflow against the true signed result, parity, and the use of the registered carry as an input. The sweeps cover every opcode over all accumulator values with sixteen spread second operands and both carry-in values, together with the two overflow examples and the write-versus-load priority.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_RLC = 4'd7,
    OP_RRC = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10
  } alu_op_e;

  localparam logic [OPW-1:0] OP_LAST = 4'd10;

  // layout S Z - H - PV N C
  typedef struct packed {
    logic s;
    logic z;
    logic u5;
    logic h;
    logic u3;
    logic pv;
    logic n;
    logic c;
  } flags_t;

  localparam logic [7:0] FLAG_MASK = 8'hD7;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W  = DW,
  localparam int unsigned HW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  logic [W-1:0] b_eff;
  logic         ci_eff;
  logic [HW:0]  lo_sum;
  logic [W:0]   full_sum;

  // subtraction as a + ~b + ~cin; borrow is inverted carry
  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    ci_eff   = sub_i ? ~cin_i : cin_i;
    lo_sum   = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, ci_eff};
    full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};
    res_o    = full_sum[W-1:0];
    c_o      = full_sum[W] ^ sub_i;
    h_o      = lo_sum[HW] ^ sub_i;
    v_o      = (a_i[W-1] == b_eff[W-1]) && (full_sum[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         h_o
);
  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    h_o   = 1'b0;
    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; h_o = 1'b1; end
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_RLC: begin res_o = {a_i[W-2:0], cin_i}; c_o = a_i[W-1]; end
      OP_RRC: begin res_o = {cin_i, a_i[W-1:1]}; c_o = a_i[0]; end
      OP_SHL: begin res_o = {a_i[W-2:0], 1'b0}; c_o = a_i[W-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[W-1:1]}; c_o = a_i[0]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  flags_t     upd_flags_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output flags_t     flags_o
);
  flags_t flags_q;

  // direct write wins over an update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (we_i)    flags_q <= flags_t'(wdata_i & FLAG_MASK);
    else if (upd_i)   flags_q <= flags_t'(upd_flags_i & FLAG_MASK);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           flag_we_i,
  input  logic [7:0]     flag_wdata_i,
  output logic [DW-1:0]  res_o,
  output logic [7:0]     flags_o
);
  alu_op_e      op;
  flags_t       flags_q;
  flags_t       flags_d;
  logic         op_valid, is_arith, commit;
  logic [DW-1:0] ar_res, lg_res, res_d, res_q;
  logic         ar_c, ar_h, ar_v, lg_c, lg_h;

  assign op       = alu_op_e'(op_i);
  assign op_valid = (op_i <= OP_LAST);
  assign is_arith = (op_i[OPW-1:2] == '0);
  assign commit   = ld_i & op_valid;

  // op bit1 selects subtract, bit0 selects use of stored carry
  alu8_arith #(.W(DW)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (op_i[0] & flags_q.c),
    .sub_i (op_i[1]),
    .res_o (ar_res),
    .c_o   (ar_c),
    .h_o   (ar_h),
    .v_o   (ar_v)
  );

  alu8_logic #(.W(DW)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (flags_q.c),
    .res_o (lg_res),
    .c_o   (lg_c),
    .h_o   (lg_h)
  );

  always_comb begin
    res_d      = is_arith ? ar_res : lg_res;
    flags_d    = '0;
    flags_d.s  = res_d[DW-1];
    flags_d.z  = (res_d == '0);
    flags_d.h  = is_arith ? ar_h : lg_h;
    flags_d.pv = is_arith ? ar_v : ~^res_d;
    flags_d.n  = is_arith & op_i[1];
    flags_d.c  = is_arith ? ar_c : lg_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (commit) res_q <= res_d;
  end

  alu8_flag_reg u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (commit),
    .upd_flags_i (flags_d),
    .we_i        (flag_we_i),
    .wdata_i     (flag_wdata_i),
    .flags_o     (flags_q)
  );

  assign res_o   = res_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ld_i,
  input logic [3:0] op_i,
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic       flag_we_i,
  input logic [7:0] flag_wdata_i,
  input logic [7:0] res_o,
  input logic [7:0] flags_o
);
  logic upd;
  assign upd = ld_i && (op_i <= 4'd10) && !flag_we_i;

  assert_unused_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0));

  assert_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> flags_o[7] == res_o[7]);

  assert_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> flags_o[6] == (res_o == 8'h00));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && (!ld_i || op_i > 4'd10)) |=> ($stable(res_o) && $stable(flags_o)));

  assert_flag_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == ($past(flag_wdata_i) & 8'hD7));

  assert_logic_cn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_i >= 4'd4 && op_i <= 4'd6) |=> (flags_o[0] == 1'b0 && flags_o[1] == 1'b0));

  assert_sub_n_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && (op_i == 4'd2 || op_i == 4'd3)) |=> flags_o[1]);

  assert_add_n_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_i >= 4'd4) |=> !flags_o[1]);
endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ld_i         (ld_i),
  .op_i         (op_i),
  .a_i          (a_i),
  .b_i          (b_i),
  .flag_we_i    (flag_we_i),
  .flag_wdata_i (flag_wdata_i),
  .res_o        (res_o),
  .flags_o      (flags_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ld_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       flag_we_i = 1'b0;
  logic [7:0] flag_wdata_i = '0;
  logic [7:0] res_o, flags_o;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alu8_core dut (.*);

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {result, flags}
  function automatic logic [15:0] model(input int op, input int a, input int b, input int cin);
    int r, s, sv, lo, c, h, v, n;
    logic [7:0] rb;
    c = 0; h = 0; v = 0; n = 0; r = 0;
    case (op)
      0, 1: begin
        if (op == 0) cin = 0;
        s = a + b + cin; r = s % 256; c = (s > 255);
        lo = (a % 16) + (b % 16) + cin; h = (lo > 15);
        sv = sgn(a) + sgn(b) + cin; v = (sv > 127 || sv < -128);
      end
      2, 3: begin
        if (op == 2) cin = 0;
        s = a - b - cin; r = (s + 256) % 256; c = (s < 0);
        lo = (a % 16) - (b % 16) - cin; h = (lo < 0);
        sv = sgn(a) - sgn(b) - cin; v = (sv > 127 || sv < -128); n = 1;
      end
      4: begin r = a & b; h = 1; end
      5: r = a | b;
      6: r = a ^ b;
      7: begin r = ((a * 2) % 256) + cin; c = a / 128; end
      8: begin r = cin * 128 + a / 2; c = a % 2; end
      9: begin r = (a * 2) % 256; c = a / 128; end
      10: begin r = a / 2; c = a % 2; end
      default: ;
    endcase
    rb = 8'(r);
    if (op >= 4) v = ($countones(rb) % 2 == 0);
    return {rb, rb[7], (rb == 0), 1'b0, 1'(h), 1'b0, 1'(v), 1'(n), 1'(c)};
  endfunction

  function automatic string tag(input int op);
    case (op)
      0, 1:    return "R1/R3/R4/R5/R8";
      2, 3:    return "R2/R3/R4/R5/R8";
      4, 5, 6: return "R6/R5/R8";
      default: return "R7/R5/R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] er, input logic [7:0] ef);
    vectors++;
    if (res_o !== er || flags_o !== ef) begin
      errors++;
      $display("FAIL %s: res=%02h flags=%02h expected res=%02h flags=%02h", req, res_o, flags_o, er, ef);
    end
  endtask

  // preset flags, then load one operation; sample at following negedge
  task automatic apply(input int op, input int a, input int b, input int cin);
    flag_we_i = 1'b1; flag_wdata_i = cin[0] ? 8'h01 : 8'h00; ld_i = 1'b0;
    @(negedge clk_i);
    flag_we_i = 1'b0; ld_i = 1'b1; op_i = 4'(op); a_i = 8'(a); b_i = 8'(b);
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run=hung expected=complete");
    finish_run();
  end

  initial begin
    logic [15:0] e;
    logic [7:0]  hold_r, hold_f;
    #(CLK_PERIOD * 2);
    check("R12 reset", 8'h00, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // overflow examples from R3
    apply(0, 8'h78, 8'h69, 0); e = model(0, 8'h78, 8'h69, 0);
    check("R3 0x78+0x69", e[15:8], e[7:0]);
    if (e[15:8] != 8'hE1 || e[2] != 1'b1 || e[0] != 1'b0) begin errors++; $display("FAIL R3 model example"); end
    apply(0, 8'hFB, 8'hF0, 0); e = model(0, 8'hFB, 8'hF0, 0);
    check("R3 0xFB+0xF0", e[15:8], e[7:0]);

    // sweep: every opcode, all a, 16 spread b values, carry in alternates
    for (int op = 0; op <= 10; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 16; bi++) begin
          int b, cin;
          b = bi * 17;
          cin = (a ^ bi) & 1;
          apply(op, a, b, cin);
          e = model(op, a, b, cin);
          check(tag(op), e[15:8], e[7:0]);
        end

    // R10: ld low holds, invalid opcodes hold
    apply(0, 8'h12, 8'h34, 1);
    hold_r = res_o; hold_f = flags_o;
    op_i = 4'd2; a_i = 8'hFF; b_i = 8'h01; ld_i = 1'b0;
    @(negedge clk_i);
    check("R10 ld low", hold_r, hold_f);
    for (int op = 11; op < 16; op++) begin
      ld_i = 1'b1; op_i = 4'(op); a_i = 8'h80; b_i = 8'h80;
      @(negedge clk_i);
      ld_i = 1'b0;
      check("R10 invalid opcode", hold_r, hold_f);
    end

    // R9: unused bits forced to zero on write
    flag_we_i = 1'b1; flag_wdata_i = 8'h28;
    @(negedge clk_i);
    flag_we_i = 1'b0;
    check("R9 unused bits", hold_r, 8'h00);
    flag_we_i = 1'b1; flag_wdata_i = 8'hFF;
    @(negedge clk_i);
    flag_we_i = 1'b0;
    check("R9/R11 write all ones", hold_r, 8'hD7);

    // R11: write beats load flags, result still loads
    ld_i = 1'b1; op_i = 4'd0; a_i = 8'hFF; b_i = 8'h01;
    flag_we_i = 1'b1; flag_wdata_i = 8'h42;
    @(negedge clk_i);
    ld_i = 1'b0; flag_we_i = 1'b0;
    check("R11 write priority", 8'h00, 8'h42);

    // R12: async reset mid-run
    #(CLK_PERIOD / 4);
    rst_ni = 1'b0;
    #1;
    check("R12 async reset", 8'h00, 8'h00);
    finish_run();
  end
endmodule